// File: doc/BRIEF.md
# Edge-Aligned PWM Generator with Period Counter and Compare Threshold

The block turns a clock-enable tick into a pulse-width-modulated level. An internal 16-bit counter steps up by one on every tick. When it has reached the programmed period limit, the next tick brings it back to zero, so one period lasts limit+1 ticks. The output is high while the counter is below the programmed threshold and low for the rest of the period. The duty cycle is therefore threshold/(limit+1). A threshold of zero holds the output low, and a threshold above the limit holds it high.

Both settings are held in shadow registers. The block copies the input values into them only on the tick that wraps the counter. A change made in the middle of a period takes effect at the next period boundary, so the block never emits a shortened or runt pulse. The block also raises a one-clock wrap flag at each period boundary.

Top module: `pwm_wrap_cc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears itself. After that edge `cnt_o` is 0, `wrap_o` is 0 and `pwm_o` is 0.
- R2: A clock edge with `tick_i` high advances `cnt_o` by one, unless a wrap occurs at that edge. A clock edge with `tick_i` low leaves `cnt_o` unchanged.
- R3: A tick at an edge where `cnt_o` equals the active limit returns `cnt_o` to 0. The counter never exceeds the active limit, so a period lasts limit+1 ticks.
- R4: `wrap_o` is high for exactly the clock cycle that follows a wrapping edge, which is the cycle in which `cnt_o` first shows 0. It is low in every other cycle.
- R5: When the active threshold lies between 1 and the active limit, `pwm_o` is 1 while `cnt_o` is below the threshold. It is 0 from the count equal to the threshold until the end of the period, so the high time is threshold ticks.
- R6: An active threshold of 0 holds `pwm_o` at 0 for the whole period.
- R7: An active threshold greater than the active limit holds `pwm_o` at 1 for the whole period. This includes a limit of 0 with a threshold of 1.
- R8: `top_i` and `cmp_i` are copied into the active settings only at a wrapping edge. Changes to these inputs at any other time have no effect on `cnt_o`, `pwm_o` or `wrap_o` until the next wrap.
- R9: After reset the active limit and threshold are both 0. The first tick is therefore a wrap that loads `top_i` and `cmp_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Counter advance enable, one clock per tick |
| top_i | input | 16 | Requested period limit (period = limit+1 ticks) |
| cmp_i | input | 16 | Requested high-time threshold |
| pwm_o | output | 1 | PWM level |
| cnt_o | output | 16 | Current counter value |
| wrap_o | output | 1 | One-clock flag in the cycle after the counter returns to 0 |

## Verification
The bench sweeps every pairing of a small limit (0 to 5) with a threshold (0 to 7), using both a tick on every clock and a sparse, irregular tick pattern. This reaches both saturation edges and the limit-of-zero case.

The edge cases below are each aimed at a specific defect:
- A design that compares with less-or-equal would show a pulse one tick too long.
- A design that wraps one count late would stretch every period.
- A design that treats threshold 0 or threshold above the limit as ordinary values would emit a glitch pulse.

The bench also writes new settings in the middle of a period. A design without shadow registers would then produce a truncated pulse or a period of the wrong length, and the bench would see it on the very next tick.

// File: rtl/pwm_wrap_pkg.sv
// Package: shared defaults and helpers for the edge-aligned PWM generator.
// Assumes: nothing beyond a two-state counter/threshold comparison.
package pwm_wrap_pkg;

    // Default width of counter, limit and threshold
    localparam int DEF_CNT_W = 16;

    // Output level for a given count and threshold: high while below threshold
    function automatic logic level_below(input logic [DEF_CNT_W-1:0] cnt,
                                         input logic [DEF_CNT_W-1:0] thr);
        return (cnt < thr);
    endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
// Module: pwm_shadow_regs
// Holds the active period limit and threshold. It copies the requested
// values only when load_i is high, which the counter raises on a wrapping tick.
// Assumes: load_i is a single-cycle qualifier that is already gated by the tick.
module pwm_shadow_regs #(
    parameter int W = pwm_wrap_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] top_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] act_top_o,
    output logic [W-1:0] act_cmp_o
);

    logic [W-1:0] top_q;
    logic [W-1:0] cmp_q;

    // Capture the requested settings at a period boundary; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            cmp_q <= '0;
        end else if (load_i) begin
            top_q <= top_i;
            cmp_q <= cmp_i;
        end
    end

    assign act_top_o = top_q;
    assign act_cmp_o = cmp_q;

    // Active settings move only on a load strobe (R8)
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(top_q) && $stable(cmp_q)));

endmodule

// File: rtl/pwm_period_counter.sv
// Module: pwm_period_counter
// Up counter that wraps to zero on the tick after it reaches the active limit.
// It emits a registered wrap flag and a combinational load strobe for the
// shadow registers.
// Assumes: act_top_i changes only at the edge where this counter wraps.
module pwm_period_counter #(
    parameter int W = pwm_wrap_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] act_top_i,
    output logic [W-1:0] cnt_o,
    output logic         load_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;
    logic         wrap_q;
    logic         at_top;

    // Counter sits at the end of its period
    assign at_top = (cnt_q == act_top_i);
    // Wrapping tick: reload shadows at this edge
    assign load_o = tick_i && at_top;

    // Advance on tick, return to zero after the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_top ? '0 : cnt_q + W'(1);
        end
    end

    // Flag the cycle in which the counter first shows zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= load_o;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    // Without a tick the counter holds (R2)
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

    // A wrapping tick gives a flag and a zero count (R3, R4)
    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && at_top) |=> (wrap_q && cnt_q == '0));

    // A flag is only ever seen with a zero count (R4)
    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_compare_out.sv
// Module: pwm_compare_out
// Forms the PWM level from the current count and the active threshold.
// A zero threshold never goes high, and a threshold above the limit never
// goes low, because the count cannot exceed the limit.
// Assumes: cnt_i and act_cmp_i are both flop outputs, so the level is glitch-free.
module pwm_compare_out #(
    parameter int W = pwm_wrap_pkg::DEF_CNT_W
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] act_cmp_i,
    output logic         pwm_o
);

    // High while the count is below the threshold
    always_comb begin
        pwm_o = (cnt_i < act_cmp_i);
    end

endmodule

// File: rtl/pwm_wrap_cc.sv
// Module: pwm_wrap_cc (top)
// Edge-aligned PWM generator: a period counter, double-buffered limit and
// threshold, and a compare stage that drives the output level.
// Assumes: tick_i is synchronous to clk; top_i and cmp_i may change at any time.
module pwm_wrap_cc #(
    parameter int W = pwm_wrap_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] top_i,
    input  logic [W-1:0] cmp_i,
    output logic         pwm_o,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] act_top;
    logic [W-1:0] act_cmp;
    logic         load;

    // Period counter and wrap flag
    pwm_period_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .act_top_i (act_top),
        .cnt_o     (cnt_o),
        .load_o    (load),
        .wrap_o    (wrap_o)
    );

    // Shadowed limit and threshold
    pwm_shadow_regs #(.W(W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .top_i     (top_i),
        .cmp_i     (cmp_i),
        .act_top_o (act_top),
        .act_cmp_o (act_cmp)
    );

    // Output compare stage
    pwm_compare_out #(.W(W)) u_cmp (
        .cnt_i     (cnt_o),
        .act_cmp_i (act_cmp),
        .pwm_o     (pwm_o)
    );

    // Count never exceeds the active limit (R3)
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= act_top);

    // At the start of a period the level is high unless the threshold is zero (R5, R6)
    assert_period_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (pwm_o == (act_cmp != '0)));

    // Threshold above the limit keeps the level high (R7)
    assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp > act_top) |-> pwm_o);

    // Outputs are cleared right after a reset edge (R1)
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 && !wrap_o && !pwm_o));

endmodule

// File: tb/sim_pwm_wrap_cc.sv
// Bench for pwm_wrap_cc. It keeps an arithmetic model of the period counter
// and the shadowed settings, and compares every cycle against it.
module sim_pwm_wrap_cc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [15:0] top_i = '0;
    logic [15:0] cmp_i = '0;
    logic        pwm_o;
    logic [15:0] cnt_o;
    logic        wrap_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Model state
    int m_cnt = 0, m_top = 0, m_cmp = 0;
    bit m_wrap = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_wrap_cc u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .top_i(top_i),
        .cmp_i(cmp_i), .pwm_o(pwm_o), .cnt_o(cnt_o), .wrap_o(wrap_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Applies one clock with the given tick, advances the model, then compares
    task automatic step(input bit t);
        tick_i = t;
        @(posedge clk);
        cyc++;
        if (t && m_cnt == m_top) begin
            m_cnt = 0; m_top = int'(top_i); m_cmp = int'(cmp_i); m_wrap = 1;
        end else begin
            m_wrap = 0;
            if (t) m_cnt = m_cnt + 1;
        end
        @(negedge clk);
        check(t ? "R3 count" : "R2 count", int'(cnt_o), m_cnt);
        check("R4 wrap", int'(wrap_o), int'(m_wrap));
        if (m_cmp == 0)          check("R6 level", int'(pwm_o), 0);
        else if (m_cmp > m_top)  check("R7 level", int'(pwm_o), 1);
        else                     check("R5 level", int'(pwm_o), int'(m_cnt < m_cmp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_i = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_top = 0; m_cmp = 0; m_wrap = 0;
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 wrap", int'(wrap_o), 0);
        check("R1 pwm", int'(pwm_o), 0);
    endtask

    // Watchdog
    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R9: idle ticks load nothing; the first tick wraps and loads
        top_i = 16'd3; cmp_i = 16'd2;
        step(0); step(0);
        check("R9 idle pwm", int'(pwm_o), 0);
        step(1);
        check("R9 first tick wraps", int'(wrap_o), 1);
        check("R9 loaded threshold", int'(pwm_o), 1);

        // Sweep of limit and threshold, dense and sparse ticks (R2..R7)
        for (int mode = 0; mode < 2; mode++) begin
            for (int tp = 0; tp < 6; tp++) begin
                for (int cp = 0; cp < 8; cp++) begin
                    top_i = 16'(tp); cmp_i = 16'(cp);
                    for (int k = 0; k < 4 * (tp + 1) * 3; k++) begin
                        step(mode == 0 ? 1'b1 : 1'(((k * 7) % 5) < 3));
                    end
                end
            end
        end

        // R7 corner: limit 0, threshold 1 stays high on every tick
        top_i = 16'd0; cmp_i = 16'd1;
        for (int k = 0; k < 10; k++) step(1);
        check("R7 limit0 thr1", int'(pwm_o), 1);

        // R8: mid-period writes take effect only at the next wrap
        do_reset();
        top_i = 16'd9; cmp_i = 16'd5;
        step(1);                                   // wrap, load 9/5
        for (int k = 0; k < 3; k++) step(1);       // count 3
        top_i = 16'd2; cmp_i = 16'd1;
        for (int k = 0; k < 3; k++) step(1);       // count 6, still old settings
        check("R8 count unaffected", int'(cnt_o), 6);
        check("R8 no early wrap", int'(wrap_o), 0);
        for (int k = 0; k < 3; k++) step(1);       // count 9
        step(1);                                   // wrap, new settings
        check("R8 wrap at old limit", int'(wrap_o), 1);
        for (int k = 0; k < 8; k++) step(1);

        // Longer period with a mid-range threshold (R3, R5)
        top_i = 16'd300; cmp_i = 16'd150;
        for (int k = 0; k < 700; k++) step(1);

        // Large threshold at the top of the range (R7)
        top_i = 16'd20; cmp_i = 16'hFFFF;
        for (int k = 0; k < 60; k++) step(1);

        // Reset in mid-period (R1)
        top_i = 16'd7; cmp_i = 16'd4;
        for (int k = 0; k < 12; k++) step(1);
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule